// File: doc/BRIEF.md
# Translation Cache with Page Protection

This block is a small fully associative cache of address translations. A lookup presents a virtual page number together with the kind of access (read or write) and the privilege of the requester (supervisor or user). In the same cycle the block returns one of three outcomes: a hit with its physical frame number, a miss, or a protection fault. A fault is raised when the cached page is marked absent, when a write targets a read-only page, or when a user-mode access targets a supervisor-only page.

On a miss the block asks an external page-table walker for the translation, holding the request and the page number until the walker answers on the refill port. The answer is stored in the first free slot; when every slot is occupied, a rotating pointer chooses the victim. The first permitted write to a page whose modified flag is clear sets that flag and raises a one-cycle mark, so the owner of the page table can record the change. A flush input empties the whole cache in one cycle and cancels any outstanding walk.

The walk controller has two states. In IDLE no walk is outstanding, and a lookup miss moves it to WAIT (transition *start*). In WAIT the walk request is held; a refill returns it to IDLE and installs the entry (transition *install*), and a flush returns it to IDLE with nothing installed (transition *abort*). A flush has priority over a refill in the same cycle.

Top module: `xlat_cache`

## Requirements
- R1: A lookup whose page number matches a valid entry and passes the protection check gives `res_kind` = 2'b01 (hit) and that entry's frame number on `res_pfn` in the same cycle, with no clock edge in between.
- R2: A lookup miss while no walk is outstanding raises `walk_req` from the next cycle on, with `walk_vpn` equal to the missing page number. Both hold until a refill or a flush arrives.
- R3: A refill (`fill_valid`) while `walk_req` is high stores `walk_vpn` with the supplied frame number and permission bits, and drops `walk_req` on the next cycle. Later lookups of that page hit.
- R4: A write to an entry whose writable bit is clear gives `res_kind` = 2'b11 (fault). A read of the same entry is allowed.
- R5: A user-mode access (`lk_user` = 1) to an entry whose user bit is clear gives a fault. A supervisor access to the same entry is allowed.
- R6: Any access to an entry whose present bit is clear gives a fault.
- R7: A permitted write that hits an entry whose dirty bit is clear pulses `dirty_mark` in that cycle and sets the bit. Later writes to the entry, reads, and faulting accesses do not pulse it.
- R8: A refill goes into the lowest-numbered empty slot. When all slots are full, the victims are chosen in rotating order, starting from slot 0 after reset.
- R9: `flush` empties every entry at the next edge and cancels an outstanding walk. From the next cycle on, every lookup misses and `walk_req` is low.
- R10: `res_kind` is 2'b00 when `lk_valid` is low and 2'b10 on a miss. A miss while a walk is outstanding neither restarts the walk nor changes `walk_vpn`. Hits and faults are still answered while a walk is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_write | input | 1 | Lookup is a write (1) or a read (0) |
| lk_user | input | 1 | Lookup comes from user mode |
| res_kind | output | 2 | 00 none, 01 hit, 10 miss, 11 fault |
| res_pfn | output | PFN_W | Frame number on a hit, zero otherwise |
| dirty_mark | output | 1 | First write to a clean page, flag must be written back |
| walk_req | output | 1 | Translation request to the walker |
| walk_vpn | output | VPN_W | Page number the walker must resolve |
| fill_valid | input | 1 | Walker answer present |
| fill_pfn | input | PFN_W | Frame number from the walker |
| fill_present | input | 1 | Page is resident |
| fill_rw | input | 1 | Page is writable |
| fill_user | input | 1 | Page is reachable from user mode |
| fill_dirty | input | 1 | Page is already modified |
| flush | input | 1 | Empty the whole cache |

## Verification
The hardest case to reach from the ports is rotating replacement: it only happens once every slot is full, and the chosen victim can only be seen when a translation that had been cached starts to miss. The bench uses a four-entry configuration. It fills all slots with distinct pages, adds two more, and then finds out which pages were evicted by probing every one of them. Protection and dirty tracking are swept over all sixteen permission patterns, each with all four combinations of access kind and privilege, in an order where a write hit changes what the later accesses must produce.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_HIT   = 2'd1,
        RES_MISS  = 2'd2,
        RES_FAULT = 2'd3
    } res_e;

    typedef struct packed {
        logic present;
        logic rw;
        logic user;
        logic dirty;
    } perm_t;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_WAIT = 1'b1
    } walk_st_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int N     = 32,
    parameter int VPN_W = 36,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] first_free;
    logic             any_free;

    always_comb begin
        any_free   = 1'b0;
        first_free = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free   = 1'b1;
                first_free = IDX_W'(i);
            end
        end
        idx = any_free ? first_free : rr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance && !any_free) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_walk_fsm.sv
module xlat_walk_fsm
    import xlat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fill_valid,
    input  logic flush,
    output logic busy,
    output logic install
);
    walk_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WK_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d    = st_q;
        busy    = 1'b0;
        install = 1'b0;
        unique case (st_q)
            WK_IDLE: begin
                if (start && !flush) st_d = WK_WAIT;
            end
            WK_WAIT: begin
                busy = 1'b1;
                if (flush) begin
                    st_d = WK_IDLE;
                end else if (fill_valid) begin
                    install = 1'b1;
                    st_d    = WK_IDLE;
                end
            end
            default: st_d = WK_IDLE;
        endcase
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 36,
    parameter int PFN_W   = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic [1:0]       res_kind,
    output logic [PFN_W-1:0] res_pfn,
    output logic             dirty_mark,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_present,
    input  logic             fill_rw,
    input  logic             fill_user,
    input  logic             fill_dirty,
    input  logic             flush
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]            vld_q;
    logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
    perm_t                         perm_q [ENTRIES];
    logic [VPN_W-1:0]              wvpn_q;

    logic             hit;
    logic [IDX_W-1:0] hidx;
    logic [IDX_W-1:0] vidx;
    logic             busy;
    logic             install;
    logic             start;
    logic             deny;
    perm_t            hperm;
    res_e             res;

    xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_match (
        .valid (vld_q),
        .tags  (tag_q),
        .key   (lk_vpn),
        .hit   (hit),
        .idx   (hidx)
    );

    xlat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (vld_q),
        .advance (install),
        .idx     (vidx)
    );

    xlat_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fill_valid (fill_valid),
        .flush      (flush),
        .busy       (busy),
        .install    (install)
    );

    assign hperm = perm_q[hidx];
    assign deny  = !hperm.present || (lk_write && !hperm.rw) || (lk_user && !hperm.user);
    assign start = lk_valid && !hit && !busy;

    always_comb begin
        if (!lk_valid)  res = RES_NONE;
        else if (!hit)  res = RES_MISS;
        else if (deny)  res = RES_FAULT;
        else            res = RES_HIT;
    end

    assign res_kind   = res;
    assign res_pfn    = (res == RES_HIT) ? pfn_q[hidx] : '0;
    assign dirty_mark = (res == RES_HIT) && lk_write && !hperm.dirty;
    assign walk_req   = busy;
    assign walk_vpn   = wvpn_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wvpn_q <= '0;
        end else if (start && !flush) begin
            wvpn_q <= lk_vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            tag_q <= '0;
            pfn_q <= '0;
            for (int i = 0; i < ENTRIES; i++) perm_q[i] <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else begin
            if (dirty_mark) perm_q[hidx].dirty <= 1'b1;
            if (install) begin
                vld_q[vidx]  <= 1'b1;
                tag_q[vidx]  <= wvpn_q;
                pfn_q[vidx]  <= fill_pfn;
                perm_q[vidx] <= '{present: fill_present, rw: fill_rw,
                                  user: fill_user, dirty: fill_dirty};
            end
        end
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter int VPN_W = 36,
    parameter int PFN_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_write,
    input logic [1:0]       res_kind,
    input logic [PFN_W-1:0] res_pfn,
    input logic             dirty_mark,
    input logic             walk_req,
    input logic [VPN_W-1:0] walk_vpn,
    input logic             fill_valid,
    input logic             flush
);
    // R2: a miss with no walk outstanding opens a walk for that page
    p_walk_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && res_kind == RES_MISS && !walk_req && !flush)
        |=> (walk_req && walk_vpn == $past(lk_vpn)));

    // R2, R10: an open walk keeps its page until a refill or a flush
    p_walk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid && !flush) |=> (walk_req && $stable(walk_vpn)));

    // R3: a refill closes the walk
    p_fill_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid) |=> !walk_req);

    // R9: after a flush nothing can hit and no walk is open
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!walk_req && res_kind != RES_HIT));

    // R7: the dirty mark only accompanies a permitted write hit
    p_dirty_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_mark |-> (lk_valid && lk_write && res_kind == RES_HIT));

    // R10: no outcome is reported without a lookup
    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_kind != RES_NONE) |-> lk_valid);

    // R1: a frame number only appears with a hit
    p_pfn_on_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_pfn != '0) |-> (res_kind == RES_HIT));
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vpn     (lk_vpn),
    .lk_write   (lk_write),
    .res_kind   (res_kind),
    .res_pfn    (res_pfn),
    .dirty_mark (dirty_mark),
    .walk_req   (walk_req),
    .walk_vpn   (walk_vpn),
    .fill_valid (fill_valid),
    .flush      (flush)
);

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;
    localparam int N  = 4;
    localparam int VW = 8;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic          lk_write = 1'b0;
    logic          lk_user = 1'b0;
    logic [1:0]    res_kind;
    logic [PW-1:0] res_pfn;
    logic          dirty_mark;
    logic          walk_req;
    logic [VW-1:0] walk_vpn;
    logic          fill_valid = 1'b0;
    logic [PW-1:0] fill_pfn = '0;
    logic          fill_present = 1'b0;
    logic          fill_rw = 1'b0;
    logic          fill_user = 1'b0;
    logic          fill_dirty = 1'b0;
    logic          flush = 1'b0;

    int  ntests = 0;
    int  nfail  = 0;
    bit  done   = 1'b0;

    localparam logic [1:0] K_NONE = 2'd0, K_HIT = 2'd1, K_MISS = 2'd2, K_FAULT = 2'd3;

    always #2.5 clk = ~clk;

    xlat_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_write(lk_write), .lk_user(lk_user), .res_kind(res_kind),
        .res_pfn(res_pfn), .dirty_mark(dirty_mark), .walk_req(walk_req),
        .walk_vpn(walk_vpn), .fill_valid(fill_valid), .fill_pfn(fill_pfn),
        .fill_present(fill_present), .fill_rw(fill_rw), .fill_user(fill_user),
        .fill_dirty(fill_dirty), .flush(flush)
    );

    function automatic logic [PW-1:0] pfn_of(input logic [VW-1:0] v);
        return v ^ 8'hA5;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        ntests++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic look(input logic [VW-1:0] v, input logic w, input logic u,
                        output logic [1:0] k, output logic [PW-1:0] p, output logic dm);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v; lk_write = w; lk_user = u;
        #1;
        k = res_kind; p = res_pfn; dm = dirty_mark;
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [PW-1:0] p, input logic [3:0] pm);
        @(negedge clk);
        fill_valid = 1'b1; fill_pfn = p;
        {fill_present, fill_rw, fill_user, fill_dirty} = pm;
        @(posedge clk);
        #1 fill_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
    endtask

    task automatic install(input logic [VW-1:0] v, input logic [PW-1:0] p,
                           input logic [3:0] pm, input string req);
        logic [1:0] k; logic [PW-1:0] pp; logic dm;
        look(v, 1'b0, 1'b0, k, pp, dm);
        check(req, "miss before refill", 32'(k), 32'(K_MISS));
        check(req, "walk_req raised", 32'(walk_req), 32'd1);
        check(req, "walk_vpn", 32'(walk_vpn), 32'(v));
        fill(p, pm);
        check(req, "walk_req dropped", 32'(walk_req), 32'd0);
    endtask

    initial begin : main
        logic [1:0]    k;
        logic [PW-1:0] p;
        logic          dm;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state, no lookup
        @(negedge clk);
        check("R10", "idle kind", 32'(res_kind), 32'(K_NONE));
        check("R2", "no walk after reset", 32'(walk_req), 32'd0);
        check("R7", "no dirty mark after reset", 32'(dirty_mark), 32'd0);

        // R2, R3, R1: miss, walk, refill, hit
        install(8'h11, pfn_of(8'h11), 4'b1110, "R3");
        look(8'h11, 1'b0, 1'b0, k, p, dm);
        check("R1", "hit kind", 32'(k), 32'(K_HIT));
        check("R1", "hit pfn", 32'(p), 32'(pfn_of(8'h11)));

        // R10: second miss during a walk does not move it; hits still answered
        look(8'h22, 1'b0, 1'b0, k, p, dm);
        check("R2", "walk for 22", 32'(walk_vpn), 32'h22);
        look(8'h33, 1'b0, 1'b0, k, p, dm);
        check("R10", "miss during walk", 32'(k), 32'(K_MISS));
        check("R10", "walk_vpn kept", 32'(walk_vpn), 32'h22);
        check("R10", "walk still open", 32'(walk_req), 32'd1);
        look(8'h11, 1'b0, 1'b0, k, p, dm);
        check("R10", "hit during walk", 32'(k), 32'(K_HIT));
        fill(pfn_of(8'h22), 4'b1110);
        check("R3", "walk closed", 32'(walk_req), 32'd0);
        look(8'h22, 1'b0, 1'b0, k, p, dm);
        check("R3", "refilled page hits", 32'(k), 32'(K_HIT));
        check("R3", "refilled pfn", 32'(p), 32'(pfn_of(8'h22)));
        look(8'h33, 1'b0, 1'b0, k, p, dm);
        check("R10", "dropped miss not installed", 32'(k), 32'(K_MISS));

        // R9: flush cancels the walk and empties the cache
        do_flush();
        check("R9", "walk cancelled", 32'(walk_req), 32'd0);
        look(8'h11, 1'b0, 1'b0, k, p, dm);
        check("R9", "11 gone", 32'(k), 32'(K_MISS));
        do_flush();
        look(8'h22, 1'b0, 1'b0, k, p, dm);
        check("R9", "22 gone", 32'(k), 32'(K_MISS));
        do_flush();

        // R4, R5, R6, R7: every permission pattern against every access kind
        // permission bits {present, rw, user, dirty}
        for (int pm = 0; pm < 16; pm++) begin
            logic [VW-1:0] v;
            logic          dty;
            v   = VW'(8'h40 + pm);
            dty = pm[0];
            install(v, pfn_of(v), 4'(pm), "R3");
            for (int acc = 0; acc < 5; acc++) begin
                logic w, u, bad;
                logic [1:0] ek;
                w   = (acc >= 2) ? ((acc == 4) ? 1'b1 : 1'b1) : 1'b0;
                u   = (acc == 4) ? 1'b0 : acc[0];
                bad = !pm[3] || (w && !pm[2]) || (u && !pm[1]);
                ek  = bad ? K_FAULT : K_HIT;
                look(v, w, u, k, p, dm);
                if (!pm[3])
                    check("R6", $sformatf("absent pm=%0h acc=%0d", pm, acc), 32'(k), 32'(ek));
                else if (w && !pm[2])
                    check("R4", $sformatf("read-only pm=%0h acc=%0d", pm, acc), 32'(k), 32'(ek));
                else if (u && !pm[1])
                    check("R5", $sformatf("user deny pm=%0h acc=%0d", pm, acc), 32'(k), 32'(ek));
                else begin
                    check("R4", $sformatf("allowed pm=%0h acc=%0d", pm, acc), 32'(k), 32'(ek));
                    check("R1", $sformatf("pfn pm=%0h acc=%0d", pm, acc), 32'(p), 32'(pfn_of(v)));
                end
                check("R7", $sformatf("dirty mark pm=%0h acc=%0d", pm, acc),
                      32'(dm), 32'(!bad && w && !dty));
                if (!bad && w) dty = 1'b1;
            end
            do_flush();
        end

        // R8: empty slots first, then rotating victims from slot 0
        for (int i = 0; i < N + 2; i++) begin
            install(VW'(8'h80 + i), pfn_of(VW'(8'h80 + i)), 4'b1110, "R8");
        end
        for (int i = 2; i < N + 2; i++) begin
            look(VW'(8'h80 + i), 1'b0, 1'b0, k, p, dm);
            check("R8", $sformatf("kept %0h", 8'h80 + i), 32'(k), 32'(K_HIT));
            check("R8", $sformatf("kept pfn %0h", 8'h80 + i), 32'(p), 32'(pfn_of(VW'(8'h80 + i))));
        end
        look(8'h80, 1'b0, 1'b0, k, p, dm);
        check("R8", "slot 0 evicted first", 32'(k), 32'(K_MISS));
        look(8'h81, 1'b0, 1'b0, k, p, dm);
        check("R8", "slot 1 evicted second", 32'(k), 32'(K_MISS));
        do_flush();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            ntests++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end
endmodule